// File: doc/BRIEF.md
# Dual-Nybble CPU Status Register with Halt

This block stores the processor status as two 4-bit nybbles. The low nybble holds the arithmetic flags: negative, zero, carry and overflow. The ALU updates these flags one bit at a time through a per-bit enable mask. The high nybble holds the interrupt mask flag and the halt flag. It also holds two constant bits, which always read 0 and 1. The core reads both nybbles together as one 8-bit status vector.

Software changes flags with read-modify-write sequences. It reads a nybble, ANDs it to clear bits or ORs it to set them, and writes the result back through the direct write port. The halt flag is sticky. A direct write can set it, but only reset or an interrupt request arriving while the mask flag is 1 can clear it. The `halted` output follows the halt flag and stalls the rest of the CPU.

Top module: `status_nybble_reg`

## Requirements
- R1: Reset clears N, Z, C, O, I and H, so `status` reads 8'h80 and `halted` reads 0.
- R2: When `alu_we` is 1, each low-nybble bit k with `alu_mask[k]`=1 takes `alu_flags[k]`, and the other bits hold. The bit positions are N=bit 0, Z=bit 1, C=bit 2, O=bit 3.
- R3: A direct write with `wr_en`=1 and `wr_sel`=0 loads `wr_data` into `status[3:0]` on the next edge.
- R4: When a direct low-nybble write and an ALU update occur in the same cycle, the direct write wins on every bit.
- R5: `status[6]` always reads 0 and `status[7]` always reads 1. Writes to those positions have no effect.
- R6: A direct write with `wr_sel`=1 loads `wr_data[0]` into the interrupt mask flag I, which is `status[4]`.
- R7: A direct write with `wr_sel`=1 and `wr_data[1]`=1 sets the halt flag H (`status[5]`). `halted` then reads 1 from the next cycle.
- R8: Once H is 1, a high-nybble write with `wr_data[1]`=0 does not clear it.
- R9: `irq`=1 while I is 1 clears H on the next edge. `irq` while I is 0 leaves H set.
- R10: When a wake-up (`irq` with the current I=1) coincides with a write that sets H, H ends at 0. The wake-up uses the value of I from before that write.
- R11: ALU updates never change the high nybble, and high-nybble writes never change the low nybble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_we | input | 1 | ALU flag update strobe |
| alu_mask | input | 4 | Per-flag update enable |
| alu_flags | input | 4 | New flag values from the ALU |
| wr_en | input | 1 | Direct nybble write strobe |
| wr_sel | input | 1 | Write target: 0 = arithmetic nybble, 1 = control nybble |
| wr_data | input | 4 | Nybble to write |
| irq | input | 1 | Interrupt request |
| status | output | 8 | {control nybble, arithmetic nybble} |
| halted | output | 1 | CPU stall, equal to the halt flag |

## Verification
The bench writes to the high nybble in ways that try to flip the constant bits. A design that stored those bits would report a wrong status vector afterwards. It attempts to clear halt with a plain write and wakes the core with the interrupt mask both clear and set. A non-sticky halt, or one that ignored the mask, would show up on `halted`. It also collides an ALU update with a direct write, and a wake-up with a halt-setting write that also clears the mask. Getting the priority wrong, or using the newly written mask value, would leave the wrong flag values or a stuck halt.

// File: rtl/sr_pkg.sv
package sr_pkg;
   // Arithmetic nybble bit positions
   localparam int unsigned NEG_POS  = 0;
   localparam int unsigned ZERO_POS = 1;
   localparam int unsigned CARRY_POS = 2;
   localparam int unsigned OVF_POS  = 3;
   // Control nybble bit positions
   localparam int unsigned IMASK_POS = 0;
   localparam int unsigned HALT_POS  = 1;
   localparam int unsigned LOW_POS   = 2;
   localparam int unsigned HIGH_POS  = 3;

   typedef enum logic {
      TGT_ARITH = 1'b0,
      TGT_CTRL  = 1'b1
   } wr_target_e;
endpackage

// File: rtl/sr_wr_decode.sv
module sr_wr_decode (
   input  logic wr_en,
   input  logic wr_sel,
   output logic wr_arith,
   output logic wr_ctrl
);
   import sr_pkg::*;

   wr_target_e tgt;

   always_comb begin
      tgt      = wr_target_e'(wr_sel);
      wr_arith = wr_en && (tgt == TGT_ARITH);
      wr_ctrl  = wr_en && (tgt == TGT_CTRL);
   end
endmodule

// File: rtl/sr_flag_bank.sv
module sr_flag_bank #(
   parameter int unsigned NYB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_arith,
   input  logic [NYB_W-1:0] wr_data,
   input  logic             alu_we,
   input  logic [NYB_W-1:0] alu_mask,
   input  logic [NYB_W-1:0] alu_flags,
   output logic [NYB_W-1:0] flags_q
);
   // One independent flop per flag. A direct write beats the ALU on every bit.
   for (genvar k = 0; k < NYB_W; k++) begin : g_flag
      logic alu_hit;
      assign alu_hit = alu_we && alu_mask[k];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q[k] <= 1'b0;
         end else if (wr_arith) begin
            flags_q[k] <= wr_data[k];
         end else if (alu_hit) begin
            flags_q[k] <= alu_flags[k];
         end
      end
   end
endmodule

// File: rtl/sr_ctrl_bank.sv
module sr_ctrl_bank #(
   parameter int unsigned NYB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_imask,
   input  logic             wr_halt,
   input  logic             irq,
   output logic [NYB_W-1:0] ctrl_nyb,
   output logic             halt_q
);
   import sr_pkg::*;

   logic imask_q;
   logic wake;

   // Wake-up uses the mask value held before any write in this cycle
   assign wake = irq && imask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imask_q <= 1'b0;
      end else if (wr_ctrl) begin
         imask_q <= wr_imask;
      end
   end

   // Halt is sticky: writes can only set it, and wake-up clears it with priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
      end else if (wake) begin
         halt_q <= 1'b0;
      end else if (wr_ctrl && wr_halt) begin
         halt_q <= 1'b1;
      end
   end

   always_comb begin
      ctrl_nyb            = '0;
      ctrl_nyb[IMASK_POS] = imask_q;
      ctrl_nyb[HALT_POS]  = halt_q;
      ctrl_nyb[LOW_POS]   = 1'b0;
      ctrl_nyb[HIGH_POS]  = 1'b1;
   end
endmodule

// File: rtl/status_nybble_reg.sv
module status_nybble_reg #(
   parameter int unsigned NYB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alu_we,
   input  logic [NYB_W-1:0] alu_mask,
   input  logic [NYB_W-1:0] alu_flags,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [NYB_W-1:0] wr_data,
   input  logic             irq,
   output logic [2*NYB_W-1:0] status,
   output logic             halted
);
   import sr_pkg::*;

   localparam int unsigned ST_W = 2 * NYB_W;

   if (NYB_W != 4) begin : g_width_chk
      $error("status_nybble_reg: NYB_W must be 4");
   end

   logic             wr_arith;
   logic             wr_ctrl;
   logic [NYB_W-1:0] arith_q;
   logic [NYB_W-1:0] ctrl_q;
   logic             halt_q;

   sr_wr_decode u_dec (
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_arith (wr_arith),
      .wr_ctrl  (wr_ctrl)
   );

   sr_flag_bank #(.NYB_W(NYB_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_arith  (wr_arith),
      .wr_data   (wr_data),
      .alu_we    (alu_we),
      .alu_mask  (alu_mask),
      .alu_flags (alu_flags),
      .flags_q   (arith_q)
   );

   sr_ctrl_bank #(.NYB_W(NYB_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_imask (wr_data[IMASK_POS]),
      .wr_halt  (wr_data[HALT_POS]),
      .irq      (irq),
      .ctrl_nyb (ctrl_q),
      .halt_q   (halt_q)
   );

   assign status = ST_W'({ctrl_q, arith_q});
   assign halted = halt_q;
endmodule

// File: rtl/sr_chk.sv
module sr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       alu_we,
   input logic       wr_en,
   input logic       wr_sel,
   input logic [3:0] wr_data,
   input logic       irq,
   input logic [7:0] status,
   input logic       halted
);
   // R5
   const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[7:6] == 2'b10);

   // R7
   halt_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted == status[5]);

   // R7
   halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_data[1] && !(irq && status[4])) |=> halted);

   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !(irq && status[4])) |=> halted);

   // R9
   halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && status[4]) |=> !halted);

   // R4
   arith_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> status[3:0] == $past(wr_data));

   // R11
   arith_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_we && !(wr_en && !wr_sel)) |=> $stable(status[3:0]));

   // R6
   imask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> status[4] == $past(wr_data[0]));
endmodule

bind status_nybble_reg sr_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .alu_we  (alu_we),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .irq     (irq),
   .status  (status),
   .halted  (halted)
);

// File: tb/sim_status_nybble_reg.sv
module sim_status_nybble_reg;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alu_we = 1'b0;
   logic [3:0] alu_mask = '0;
   logic [3:0] alu_flags = '0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [3:0] wr_data = '0;
   logic       irq = 1'b0;
   logic [7:0] status;
   logic       halted;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   status_nybble_reg u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .alu_we    (alu_we),
      .alu_mask  (alu_mask),
      .alu_flags (alu_flags),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .irq       (irq),
      .status    (status),
      .halted    (halted)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive for one edge, then return to idle; sampled at the following negedge
   task automatic step(input logic a_we, input logic [3:0] a_m, input logic [3:0] a_f,
                       input logic w_en, input logic w_sel, input logic [3:0] w_d,
                       input logic rq);
      alu_we = a_we; alu_mask = a_m; alu_flags = a_f;
      wr_en = w_en; wr_sel = w_sel; wr_data = w_d; irq = rq;
      @(negedge clk);
      alu_we = 1'b0; alu_mask = '0; alu_flags = '0;
      wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; irq = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 status in reset", status, 8'h80);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", status, 8'h80);
      chk("R1 halted after reset", {7'b0, halted}, 8'h00);
   endtask

   task automatic t_alu();
      step(1, 4'b0101, 4'b1111, 0, 0, 4'h0, 0);
      chk("R2 masked set N,C", status, 8'h85);
      step(1, 4'b0001, 4'b0000, 0, 0, 4'h0, 0);
      chk("R2 clear N only", status, 8'h84);
      step(1, 4'b1010, 4'b1010, 0, 0, 4'h0, 0);
      chk("R2 set Z,O", status, 8'h8E);
      step(1, 4'b0000, 4'b1111, 0, 0, 4'h0, 0);
      chk("R2 empty mask holds", status, 8'h8E);
   endtask

   task automatic t_arith_write();
      step(0, 4'h0, 4'h0, 1, 0, 4'b0110, 0);
      chk("R3 direct arith write", status, 8'h86);
      step(1, 4'b1111, 4'b1001, 1, 0, 4'b0011, 0);
      chk("R4 write beats ALU", status, 8'h83);
   endtask

   task automatic t_const();
      step(0, 4'h0, 4'h0, 1, 1, 4'b0100, 0);
      chk("R5 const bits after 0100 write", status, 8'h83);
      step(0, 4'h0, 4'h0, 1, 1, 4'b0000, 0);
      chk("R5 const bits after 0000 write", status, 8'h83);
   endtask

   task automatic t_imask();
      step(0, 4'h0, 4'h0, 1, 1, 4'b0001, 0);
      chk("R6 set I", status, 8'h93);
      step(0, 4'h0, 4'h0, 1, 1, 4'b0000, 0);
      chk("R6 clear I", status, 8'h83);
   endtask

   task automatic t_halt();
      step(0, 4'h0, 4'h0, 1, 1, 4'b0010, 0);
      chk("R7 halt set status", status, 8'hA3);
      chk("R7 halted output", {7'b0, halted}, 8'h01);
      step(0, 4'h0, 4'h0, 1, 1, 4'b0000, 0);
      chk("R8 write cannot clear H", status, 8'hA3);
      step(1, 4'b1111, 4'b0000, 0, 0, 4'h0, 0);
      chk("R11 ALU leaves ctrl nybble", status, 8'hA0);
      step(0, 4'h0, 4'h0, 0, 0, 4'h0, 1);
      chk("R9 irq with I=0 keeps halt", {7'b0, halted}, 8'h01);
      step(0, 4'h0, 4'h0, 1, 1, 4'b0011, 0);
      chk("R11 ctrl write leaves arith nybble", status, 8'hB0);
      step(0, 4'h0, 4'h0, 0, 0, 4'h0, 1);
      chk("R9 irq with I=1 wakes", status, 8'h90);
      chk("R9 halted released", {7'b0, halted}, 8'h00);
   endtask

   task automatic t_race();
      step(0, 4'h0, 4'h0, 1, 1, 4'b0011, 1);
      chk("R10 wake beats halt write", status, 8'h90);
      step(0, 4'h0, 4'h0, 1, 1, 4'b0010, 1);
      chk("R10 wake uses old I", status, 8'h80);
      chk("R10 halted low", {7'b0, halted}, 8'h00);
   endtask

   task automatic t_reset_mid();
      step(0, 4'h0, 4'h0, 1, 0, 4'b1111, 0);
      step(0, 4'h0, 4'h0, 1, 1, 4'b0011, 0);
      chk("R1 pre-reset state", status, 8'hBF);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset clears all flags", status, 8'h80);
      chk("R1 reset clears halt", {7'b0, halted}, 8'h00);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_alu();
      t_arith_write();
      t_const();
      t_imask();
      t_halt();
      t_race();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule